// File: doc/BRIEF.md
# Column-Path Multicast Partitioner

This block sits at the injection point of a path-based multicast in a K x K mesh. A request carries a destination bitmap and the coordinates of the sending node. The block sorts the destinations by mesh column and by vertical side of the sending row, then emits one header beat for each non-empty group. Each beat names the column the copy travels to, a side flag, a destination count and an ordered list of row indices. Downstream logic routes each copy along the source row to its column first, then along that column. This order keeps the scheme compatible with dimension-ordered routing.

A column gets at most two copies. One copy serves every destination at or above the source row. The other serves every destination below it. A column with destinations on one side only gets a single copy. The sending node itself is never a destination. When the last copy has been taken, or when nothing was left to send, the block raises a one-cycle completion pulse and returns to accepting requests.

Top module: `cmcast_partitioner`

## Requirements
- R1: After reset, `out_valid` and `done` are low and `in_ready` is high. A request is taken only while `in_ready` is high. `in_ready` stays low from the cycle after acceptance until the cycle after `done`.
- R2: Bit `y*K + x` of `in_dests` marks node (column x, row y). All marked nodes in one column with row >= source row are carried by a single copy with `out_lower` = 0.
- R3: All marked nodes in one column with row < source row are carried by a single copy with `out_lower` = 1.
- R4: No copy is empty. A column with destinations on one side only gets exactly one copy, and no column gets more than two. Across all copies of a request, every destination appears exactly once.
- R5: Copies leave in ascending column order. Within a column, the `out_lower` = 0 copy comes before the `out_lower` = 1 copy. The next copy is presented in the cycle after the previous one is accepted.
- R6: `out_rows` holds `out_cnt` row indices of `log2(K)` bits each, entry 0 in the lowest bits, and unused entries are zero. Upper lists run from the source row upward. Lower lists run from the row just below the source downward.
- R7: A bitmap bit at the sending node's own position is dropped and appears in no list.
- R8: `done` is high for exactly one cycle, in the cycle after the last copy is accepted. If no destination remains after the sending node's bit is dropped, `done` is high in the cycle after acceptance and no copy is emitted. `out_valid` is low while `done` is high.
- R9: While `out_valid` is high and `out_ready` is low, every header output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| in_dests | input | K*K | Destination bitmap, bit y*K+x for node (x, y) |
| in_src_x | input | log2(K) | Source column |
| in_src_y | input | log2(K) | Source row |
| out_valid | output | 1 | Copy header present |
| out_ready | input | 1 | Downstream takes the header |
| out_col | output | log2(K) | Target column of the copy |
| out_lower | output | 1 | 0: rows at or above source row, 1: rows below |
| out_cnt | output | log2(K+1) | Number of destinations in the list |
| out_rows | output | K*log2(K) | Ordered row list, nearest first |
| done | output | 1 | One-cycle completion pulse |

## Verification
The upper and lower copies of a column are presented in back-to-back cycles. The handshake that removes one group from the remaining set must therefore land in the same edge where the next group is picked. The bench provokes this with the source in a column that also holds destinations on both sides, and with the bitmap full, while `out_ready` is held high, toggled, and driven pseudo-randomly. A model built from queues predicts the valid line, the completion pulse and the full header on every clock. The bench also checks after each request that the emitted lists add up to the input bitmap without the source bit, with no column served more than twice.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } cmc_state_e;

  localparam logic SIDE_UPPER = 1'b0;
  localparam logic SIDE_LOWER = 1'b1;
endpackage

// File: rtl/cmc_group_flags.sv
// Marks, for every column, whether remaining destinations exist on each side
// of the source row. Flag 2c is the upper group, 2c+1 the lower group.
module cmc_group_flags #(
  parameter int K = 4,
  localparam int RW = $clog2(K)
) (
  input  logic [K*K-1:0] rem,
  input  logic [RW-1:0]  src_y,
  output logic [2*K-1:0] flags
);
  for (genvar c = 0; c < K; c++) begin : g_col
    logic up_c;
    logic lo_c;
    always_comb begin
      up_c = 1'b0;
      lo_c = 1'b0;
      for (int r = 0; r < K; r++) begin
        if (rem[r*K + c]) begin
          if (r >= int'(src_y)) up_c = 1'b1;
          else                  lo_c = 1'b1;
        end
      end
    end
    assign flags[2*c]     = up_c;
    assign flags[2*c + 1] = lo_c;
  end
endmodule

// File: rtl/cmc_group_pick.sv
// Lowest-index-first priority pick over the group flags.
module cmc_group_pick #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  flags,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (flags[i]) begin
        idx = IW'(i);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmc_list_pack.sv
// Compacts one column's destination bits into an ordered row list,
// walking outward from the source row in the chosen direction.
module cmc_list_pack #(
  parameter int K = 4,
  localparam int RW = $clog2(K),
  localparam int CNTW = $clog2(K + 1)
) (
  input  logic [K-1:0]    col_bits,
  input  logic [RW-1:0]   src_y,
  input  logic            lower,
  output logic [K*RW-1:0] rows,
  output logic [CNTW-1:0] cnt
);
  always_comb begin
    int pos;
    int row;
    rows = '0;
    pos  = 0;
    for (int i = 0; i < K; i++) begin
      row = lower ? (int'(src_y) - 1 - i) : (int'(src_y) + i);
      if (row >= 0 && row < K) begin
        if (col_bits[row]) begin
          rows[pos*RW +: RW] = RW'(row);
          pos = pos + 1;
        end
      end
    end
    cnt = CNTW'(pos);
  end
endmodule

// File: rtl/cmcast_partitioner.sv
module cmcast_partitioner
  import cmc_pkg::*;
#(
  parameter int K = 4,
  localparam int RW = $clog2(K),
  localparam int CNTW = $clog2(K + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [K*K-1:0]  in_dests,
  input  logic [RW-1:0]   in_src_x,
  input  logic [RW-1:0]   in_src_y,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [RW-1:0]   out_col,
  output logic            out_lower,
  output logic [CNTW-1:0] out_cnt,
  output logic [K*RW-1:0] out_rows,
  output logic            done
);
  localparam int NB = K * K;
  localparam int NG = 2 * K;
  localparam int GW = $clog2(NG);

  cmc_state_e    state_q, state_d;
  logic [NB-1:0] rem_q, rem_d;
  logic          rem_en;
  logic [RW-1:0] sx_q, sy_q;
  logic          ld_en;

  logic [NG-1:0] gflags;
  logic [GW-1:0] pick_idx;
  logic          pick_any;
  logic [RW-1:0] pick_col;
  logic          pick_lower;
  logic [K-1:0]  col_bits;
  logic [NB-1:0] gmask;
  logic [NB-1:0] src_onehot;
  logic          busy;
  logic          rem_any;

  cmc_group_flags #(.K(K)) u_flags (
    .rem   (rem_q),
    .src_y (sy_q),
    .flags (gflags)
  );

  cmc_group_pick #(.N(NG)) u_pick (
    .flags (gflags),
    .idx   (pick_idx),
    .any   (pick_any)
  );

  assign pick_col   = pick_idx[GW-1:1];
  assign pick_lower = pick_idx[0];

  always_comb begin
    for (int r = 0; r < K; r++) begin
      col_bits[r] = rem_q[r*K + int'(pick_col)];
    end
  end

  cmc_list_pack #(.K(K)) u_pack (
    .col_bits (col_bits),
    .src_y    (sy_q),
    .lower    (pick_lower),
    .rows     (out_rows),
    .cnt      (out_cnt)
  );

  // Bits of the selected group, cleared once its copy is accepted.
  always_comb begin
    gmask = '0;
    for (int r = 0; r < K; r++) begin
      gmask[r*K + int'(pick_col)] = pick_lower ? (r < int'(sy_q)) : (r >= int'(sy_q));
    end
  end

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      src_onehot[i] = (i == int'(in_src_y) * K + int'(in_src_x));
    end
  end

  assign busy      = (state_q == ST_BUSY);
  assign rem_any   = |rem_q;
  assign in_ready  = ~busy;
  assign out_valid = busy & pick_any;
  assign out_col   = pick_col;
  assign out_lower = pick_lower;
  assign done      = busy & ~rem_any;

  // Next-state process
  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    rem_en  = 1'b0;
    ld_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (in_valid) begin
          ld_en   = 1'b1;
          rem_en  = 1'b1;
          rem_d   = in_dests & ~src_onehot;
          state_d = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (!rem_any) begin
          state_d = ST_IDLE;
        end else if (out_ready) begin
          rem_en = 1'b1;
          rem_d  = rem_q & ~gmask;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      sx_q    <= '0;
      sy_q    <= '0;
    end else begin
      state_q <= state_d;
      if (rem_en) rem_q <= rem_d;
      if (ld_en) begin
        sx_q <= in_src_x;
        sy_q <= in_src_y;
      end
    end
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready); // R1
  AST_UPPER_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_lower |-> out_rows[RW-1:0] >= sy_q); // R2
  AST_LOWER_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_lower |-> out_rows[RW-1:0] < sy_q); // R3
  AST_NO_EMPTY_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_cnt != '0); // R4
  AST_GROUP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid || ({out_col, out_lower} > $past({out_col, out_lower}))); // R5
  AST_SRC_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_lower && out_col == sx_q |-> out_rows[RW-1:0] != sy_q); // R7
  AST_DONE_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid && !in_ready); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_col) && $stable(out_lower)
      && $stable(out_cnt) && $stable(out_rows)); // R9
endmodule

// File: tb/sim_cmcast_partitioner.sv
module sim_cmcast_partitioner;
  localparam int K = 4;
  localparam int RW = $clog2(K);
  localparam int CNTW = $clog2(K + 1);
  localparam int NB = K * K;
  localparam int CLK_PERIOD = 10;

  logic            clk;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic [NB-1:0]   in_dests;
  logic [RW-1:0]   in_src_x;
  logic [RW-1:0]   in_src_y;
  logic            out_valid;
  logic            out_ready;
  logic [RW-1:0]   out_col;
  logic            out_lower;
  logic [CNTW-1:0] out_cnt;
  logic [K*RW-1:0] out_rows;
  logic            done;

  int n_checks = 0;
  int n_fails  = 0;
  logic [15:0] lfsr = 16'hACE1;

  int              q_col[$];
  int              q_low[$];
  int              q_cnt[$];
  logic [K*RW-1:0] q_rows[$];

  cmcast_partitioner #(.K(K)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dests(in_dests), .in_src_x(in_src_x), .in_src_y(in_src_y),
    .out_valid(out_valid), .out_ready(out_ready), .out_col(out_col),
    .out_lower(out_lower), .out_cnt(out_cnt), .out_rows(out_rows), .done(done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Behavioural expectation: groups by column, upper then lower, nearest first.
  task automatic build_expect(input logic [NB-1:0] bm, input int sx, input int sy);
    q_col.delete(); q_low.delete(); q_cnt.delete(); q_rows.delete();
    for (int c = 0; c < K; c++) begin
      for (int side = 0; side < 2; side++) begin
        int cnt = 0;
        logic [K*RW-1:0] rows = '0;
        for (int i = 0; i < K; i++) begin
          int row = (side == 1) ? (sy - 1 - i) : (sy + i);
          if (row >= 0 && row < K && bm[row*K + c] && !(c == sx && row == sy)) begin
            rows[cnt*RW +: RW] = RW'(row);
            cnt++;
          end
        end
        if (cnt > 0) begin
          q_col.push_back(c); q_low.push_back(side);
          q_cnt.push_back(cnt); q_rows.push_back(rows);
        end
      end
    end
  endtask

  task automatic run_case(input logic [NB-1:0] bm, input int sx, input int sy, input int mode);
    logic [NB-1:0] got_map = '0;
    logic [NB-1:0] want_map;
    int colcnt[K];
    int stepn = 0;
    bit finished = 0;
    bit dup = 0;
    foreach (colcnt[c]) colcnt[c] = 0;
    build_expect(bm, sx, sy);
    want_map = bm;
    want_map[sy*K + sx] = 1'b0;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready idle", in_ready, 1);
    in_valid = 1'b1; in_dests = bm;
    in_src_x = RW'(sx); in_src_y = RW'(sy);
    @(posedge clk);
    while (!finished) begin
      bit hs, fin, exp_v;
      @(negedge clk);
      in_valid = 1'b0;
      in_dests = ~bm;
      step_lfsr();
      case (mode)
        0: out_ready = 1'b1;
        1: out_ready = stepn[0];
        default: out_ready = lfsr[3];
      endcase
      stepn++;
      chk(in_ready == 1'b0, "R1", "in_ready busy", in_ready, 0);
      exp_v = (q_col.size() > 0);
      chk(out_valid == exp_v, "R5", "out_valid", out_valid, exp_v);
      chk(done == !exp_v, "R8", "done", done, !exp_v);
      if (out_valid && exp_v) begin
        chk(out_col == RW'(q_col[0]), "R5", "out_col", out_col, q_col[0]);
        chk(out_lower == q_low[0][0], (q_low[0] != 0) ? "R3" : "R2", "out_lower", out_lower, q_low[0]);
        chk(out_cnt == CNTW'(q_cnt[0]), "R4", "out_cnt", out_cnt, q_cnt[0]);
        chk(out_rows == q_rows[0], "R6", "out_rows", out_rows, q_rows[0]);
      end
      hs  = out_valid && out_ready;
      fin = done;
      if (stepn > 200) begin
        chk(1'b0, "R8", "no completion", 0, 1);
        fin = 1;
      end
      @(posedge clk);
      if (hs) begin
        int col = int'(out_col);
        for (int i = 0; i < int'(out_cnt); i++) begin
          int row = int'(out_rows[i*RW +: RW]);
          if (got_map[row*K + col]) dup = 1;
          got_map[row*K + col] = 1'b1;
        end
        colcnt[col]++;
        if (q_col.size() > 0) begin
          void'(q_col.pop_front()); void'(q_low.pop_front());
          void'(q_cnt.pop_front()); void'(q_rows.pop_front());
        end
      end
      if (fin) finished = 1;
    end
    chk(got_map == want_map && !dup, "R4", "union of lists", got_map, want_map);
    chk(got_map[sy*K + sx] == 1'b0, "R7", "source absent", got_map[sy*K + sx], 0);
    for (int c = 0; c < K; c++) begin
      chk(colcnt[c] <= 2, "R4", "copies per column", colcnt[c], 2);
    end
    @(negedge clk);
    chk(out_valid == 1'b0 && done == 1'b0, "R8", "quiet after done", {out_valid, done}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_dests = '0;
    in_src_x = '0; in_src_y = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "ready after reset", in_ready, 1);

    run_case('0, 1, 2, 0);                               // R8 empty bitmap
    run_case(NB'(1) << (2*K + 1), 1, 2, 0);              // R7 only the source bit
    run_case(NB'(1) << (3*K + 0), 2, 1, 0);              // R2 single upper destination
    run_case(NB'(1) << (0*K + 3), 2, 1, 1);              // R3 single lower destination
    run_case({NB{1'b1}}, 1, 2, 0);                       // R5 full map, back to back
    run_case({NB{1'b1}}, 1, 2, 1);                       // R9 full map, toggled ready
    run_case({NB{1'b1}}, 0, 0, 2);                       // R6 corner source
    run_case({NB{1'b1}}, K-1, K-1, 2);                   // R6 opposite corner
    // Source column holding destinations on both sides (R2, R3, R7)
    run_case((NB'(1) << (0*K + 2)) | (NB'(1) << (1*K + 2)) | (NB'(1) << (3*K + 2))
             | (NB'(1) << (2*K + 2)), 2, 2, 0);
    // Column with only lower destinations gets one copy (R4)
    run_case((NB'(1) << (0*K + 1)) | (NB'(1) << (1*K + 1)), 3, 3, 2);
    for (int t = 0; t < 24; t++) begin
      logic [NB-1:0] bm;
      for (int b = 0; b < NB; b++) begin
        step_lfsr();
        bm[b] = lfsr[0] ^ lfsr[7];
      end
      step_lfsr();
      run_case(bm, int'(lfsr[1:0]) % K, int'(lfsr[5:4]) % K, t % 3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule